// File: doc/BRIEF.md
# On-Chip Data Memory Router

This block sits between the data-memory port of a small 8-bit microcontroller core and the on-chip data stores. For each access the core presents an address, an access kind (direct, indirect, move-external through an 8-bit register pointer, or move-external through a 16-bit data pointer), a read or write strobe and the write data. The block sends the access to one of these destinations:

- a 128-byte low RAM;
- a 128-byte high RAM;
- the special-function-register window, which is presented on an outward request port;
- a 256-byte extension RAM;
- off chip.

It holds the three RAM arrays and the auxiliary configuration register. That register chooses whether move-external accesses below 100h stay on chip.

The address range 80h to FFh has three meanings:

- Direct accesses reach the register window.
- Indirect accesses reach the high RAM.
- Move-external accesses reach the extension RAM, unless the configuration bit sends them off chip.

On-chip read data returns one clock after the request. A write is seen by the next access. An access that must leave the chip raises a one-cycle request carrying the full address.

Top module: `dmr_router`

## Requirements
- R1: Direct (kind 0) and indirect (kind 1) accesses with low byte 00h–7Fh reach the low RAM. Both kinds share one store, and address bits 15–8 are ignored for these kinds.
- R2: A direct access with low byte 80h–FFh, other than 8Eh, appears in the same cycle on `sfr_addr` with `sfr_rd` or `sfr_wr` and `sfr_wdata`. For a read, the value on `sfr_rdata` is returned as the read data.
- R3: An indirect access with low byte 80h–FFh reaches the high RAM. This store is separate from the register window and from the extension RAM.
- R4: With `cfg_extram` = 0, a move-external access reaches the extension RAM at address bits 7–0. Kind 2 uses the 8-bit pointer; kind 3 uses the 16-bit pointer below 0100h.
- R5: A kind 3 access with an address of 0100h or above always goes off chip, whatever `cfg_extram` holds.
- R6: With `cfg_extram` = 1, every move-external access goes off chip and leaves the extension RAM unchanged.
- R7: The auxiliary register is reached by a direct access at 8Eh. Bit 0 drives `cfg_ale_ctl`, bit 1 drives `cfg_extram` and bit 2 drives `cfg_lvadc`. After reset these bits read 110b, and a read returns them in bits 2–0.
- R8: Writes to bits 7–3 of the auxiliary register have no effect, and those bits read as 0.
- R9: For an on-chip read, `rd_valid` is high and `rd_data` holds the value exactly one clock after the request. A write becomes visible to the very next access. `rd_valid` is low otherwise.
- R10: An off-chip access raises `ext_req` for one cycle, one clock after the request. It carries `ext_we`, `ext_wdata`, `ext_ptr8` (1 for kind 2) and `ext_addr`: the full pointer for kind 3, or {00h, low byte} for kind 2. An off-chip read does not raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read request this cycle |
| req_wr | input | 1 | Write request this cycle |
| req_kind | input | 2 | 0 direct, 1 indirect, 2 move-external 8-bit pointer, 3 move-external 16-bit pointer |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | On-chip read data valid |
| rd_data | output | 8 | Read data |
| sfr_addr | output | 8 | Register window address |
| sfr_rd | output | 1 | Register window read strobe |
| sfr_wr | output | 1 | Register window write strobe |
| sfr_wdata | output | 8 | Register window write data |
| sfr_rdata | input | 8 | Register window read data, sampled in the strobe cycle |
| ext_req | output | 1 | Off-chip access pulse |
| ext_we | output | 1 | Off-chip access is a write |
| ext_ptr8 | output | 1 | Off-chip access used the 8-bit pointer |
| ext_addr | output | 16 | Off-chip address |
| ext_wdata | output | 8 | Off-chip write data |
| cfg_ale_ctl | output | 1 | Auxiliary bit 0 |
| cfg_extram | output | 1 | Auxiliary bit 1, extension RAM disable |
| cfg_lvadc | output | 1 | Auxiliary bit 2 |

## Verification
The assertions check the following on every cycle:

- The register window is strobed only for a direct address of 80h or above, and never for 8Eh.
- An off-chip request below 0100h happens only when the configuration bit was set during the request.
- Every read-valid or off-chip pulse follows a request of the matching kind.
- The configuration bits move only on a write.

The bench scenarios show the rest. Three stores answer at 80h–FFh with different contents. Extension RAM data survives a spell of off-chip routing. Writes to the reserved bits vanish. The exact data and address values appear at the stated latency.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

  typedef enum logic [1:0] {
    K_DIRECT   = 2'd0,
    K_INDIRECT = 2'd1,
    K_XPTR8    = 2'd2,
    K_XPTR16   = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    T_NONE = 3'd0,
    T_LOW  = 3'd1,
    T_HIGH = 3'd2,
    T_SFR  = 3'd3,
    T_AUX  = 3'd4,
    T_ERAM = 3'd5,
    T_OFF  = 3'd6
  } tgt_e;

endpackage

// File: rtl/dmr_decode.sv
module dmr_decode
  import dmr_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          LOW_DEPTH  = 128,
  parameter int          ERAM_DEPTH = 256,
  parameter logic [7:0]  AUX_ADDR   = 8'h8E
) (
  input  kind_e             kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              extram,
  output tgt_e              tgt
);

  localparam logic [7:0]        LOW_LIM  = 8'(LOW_DEPTH);
  localparam logic [ADDR_W-1:0] ERAM_LIM = ADDR_W'(ERAM_DEPTH);

  logic [7:0] a8;
  logic       below_low;
  logic       in_eram_range;

  assign a8            = addr[7:0];
  assign below_low     = (a8 < LOW_LIM);
  assign in_eram_range = (addr < ERAM_LIM);

  always_comb begin
    tgt = T_NONE;
    unique case (kind)
      K_DIRECT: begin
        if (below_low)             tgt = T_LOW;
        else if (a8 == AUX_ADDR)   tgt = T_AUX;
        else                       tgt = T_SFR;
      end
      K_INDIRECT: begin
        tgt = below_low ? T_LOW : T_HIGH;
      end
      K_XPTR8: begin
        tgt = extram ? T_OFF : T_ERAM;
      end
      K_XPTR16: begin
        if (!in_eram_range || extram) tgt = T_OFF;
        else                          tgt = T_ERAM;
      end
      default: tgt = T_NONE;
    endcase
  end

endmodule

// File: rtl/dmr_spram.sv
module dmr_spram #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/dmr_auxreg.sv
module dmr_auxreg #(
  parameter int             DW    = 8,
  parameter int             AUX_W = 3,
  parameter logic [AUX_W-1:0] RST_VAL = 3'b110
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  output logic [AUX_W-1:0] bits,
  output logic [DW-1:0]    rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bits  <= RST_VAL;
      rdata <= '0;
    end else begin
      if (wr_en) bits <= wdata[AUX_W-1:0];
      if (rd_en) rdata <= {{(DW-AUX_W){1'b0}}, bits};
    end
  end

  AST_AUX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bits)); // R7

endmodule

// File: rtl/dmr_router.sv
module dmr_router
  import dmr_pkg::*;
#(
  parameter int             DW         = 8,
  parameter int             ADDR_W     = 16,
  parameter int             LOW_DEPTH  = 128,
  parameter int             ERAM_DEPTH = 256,
  parameter logic [7:0]     AUX_ADDR   = 8'h8E,
  parameter logic [2:0]     AUX_RST    = 3'b110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [7:0]        sfr_addr,
  output logic              sfr_rd,
  output logic              sfr_wr,
  output logic [DW-1:0]     sfr_wdata,
  input  logic [DW-1:0]     sfr_rdata,
  output logic              ext_req,
  output logic              ext_we,
  output logic              ext_ptr8,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DW-1:0]     ext_wdata,
  output logic              cfg_ale_ctl,
  output logic              cfg_extram,
  output logic              cfg_lvadc
);

  localparam int LOW_AW  = $clog2(LOW_DEPTH);
  localparam int HIGH_D  = 256 - LOW_DEPTH;
  localparam int HIGH_AW = $clog2(HIGH_D);
  localparam int ERAM_AW = $clog2(ERAM_DEPTH);
  localparam int AUX_W   = 3;

  tgt_e             tgt;
  tgt_e             sel_q;
  logic             rvalid_q;
  logic [DW-1:0]    q_low, q_high, q_eram, q_aux, q_sfr;
  logic [AUX_W-1:0] aux_bits;
  logic             is_off;

  dmr_decode #(
    .ADDR_W    (ADDR_W),
    .LOW_DEPTH (LOW_DEPTH),
    .ERAM_DEPTH(ERAM_DEPTH),
    .AUX_ADDR  (AUX_ADDR)
  ) u_dec (
    .kind  (kind_e'(req_kind)),
    .addr  (req_addr),
    .extram(cfg_extram),
    .tgt   (tgt)
  );

  dmr_spram #(.DW(DW), .DEPTH(LOW_DEPTH)) u_low (
    .clk  (clk),
    .we   (req_wr && tgt == T_LOW),
    .re   (req_rd && tgt == T_LOW),
    .addr (req_addr[LOW_AW-1:0]),
    .wdata(req_wdata),
    .rdata(q_low)
  );

  dmr_spram #(.DW(DW), .DEPTH(HIGH_D)) u_high (
    .clk  (clk),
    .we   (req_wr && tgt == T_HIGH),
    .re   (req_rd && tgt == T_HIGH),
    .addr (req_addr[HIGH_AW-1:0]),
    .wdata(req_wdata),
    .rdata(q_high)
  );

  dmr_spram #(.DW(DW), .DEPTH(ERAM_DEPTH)) u_eram (
    .clk  (clk),
    .we   (req_wr && tgt == T_ERAM),
    .re   (req_rd && tgt == T_ERAM),
    .addr (req_addr[ERAM_AW-1:0]),
    .wdata(req_wdata),
    .rdata(q_eram)
  );

  dmr_auxreg #(.DW(DW), .AUX_W(AUX_W), .RST_VAL(AUX_RST)) u_aux (
    .clk  (clk),
    .rst  (rst),
    .wr_en(req_wr && tgt == T_AUX),
    .rd_en(req_rd && tgt == T_AUX),
    .wdata(req_wdata),
    .bits (aux_bits),
    .rdata(q_aux)
  );

  assign cfg_ale_ctl = aux_bits[0];
  assign cfg_extram  = aux_bits[1];
  assign cfg_lvadc   = aux_bits[2];

  // register window request port
  assign sfr_addr  = req_addr[7:0];
  assign sfr_rd    = req_rd && tgt == T_SFR;
  assign sfr_wr    = req_wr && tgt == T_SFR;
  assign sfr_wdata = req_wdata;

  assign is_off = (req_rd || req_wr) && tgt == T_OFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= T_NONE;
      rvalid_q  <= 1'b0;
      q_sfr     <= '0;
      ext_req   <= 1'b0;
      ext_we    <= 1'b0;
      ext_ptr8  <= 1'b0;
      ext_addr  <= '0;
      ext_wdata <= '0;
    end else begin
      rvalid_q <= req_rd && tgt != T_OFF && tgt != T_NONE;
      sel_q    <= req_rd ? tgt : T_NONE;
      if (sfr_rd) q_sfr <= sfr_rdata;
      ext_req  <= is_off;
      if (is_off) begin
        ext_we    <= req_wr;
        ext_ptr8  <= (kind_e'(req_kind) == K_XPTR8);
        ext_addr  <= (kind_e'(req_kind) == K_XPTR8) ?
                     {{(ADDR_W-8){1'b0}}, req_addr[7:0]} : req_addr;
        ext_wdata <= req_wdata;
      end
    end
  end

  assign rd_valid = rvalid_q;

  always_comb begin
    unique case (sel_q)
      T_LOW:   rd_data = q_low;
      T_HIGH:  rd_data = q_high;
      T_ERAM:  rd_data = q_eram;
      T_AUX:   rd_data = q_aux;
      T_SFR:   rd_data = q_sfr;
      default: rd_data = '0;
    endcase
  end

  AST_SFR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (sfr_rd || sfr_wr) |-> (sfr_addr[7] && sfr_addr != AUX_ADDR)); // R2

  AST_LOW_OFF_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
    (ext_req && ext_addr[ADDR_W-1:8] == '0) |-> $past(cfg_extram)); // R6

  AST_RDV_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_rd)); // R9

  AST_EXT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    ext_req |-> $past(req_rd || req_wr)); // R10

  AST_EXT_NO_RDV: assert property (@(posedge clk) disable iff (rst)
    ext_req |-> !rd_valid); // R10

endmodule

// File: tb/test_dmr_router.sv
`timescale 1ns/1ps
module test_dmr_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_rd = 1'b0, req_wr = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        sfr_rd, sfr_wr;
  logic        ext_req, ext_we, ext_ptr8;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic        cfg_ale_ctl, cfg_extram, cfg_lvadc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_low  [128];
  logic [7:0] m_high [128];
  logic [7:0] m_eram [256];
  logic [2:0] m_aux;

  always #4 clk = ~clk;

  // peripheral stand-in: read value derived from the address
  assign sfr_rdata = sfr_addr ^ 8'h5A;

  dmr_router i_dmr_router (
    .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .ext_req(ext_req), .ext_we(ext_we), .ext_ptr8(ext_ptr8),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .cfg_ale_ctl(cfg_ale_ctl), .cfg_extram(cfg_extram), .cfg_lvadc(cfg_lvadc)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // 1 low, 2 high, 3 window, 4 aux, 5 ext RAM, 6 off chip
  function automatic int exp_tgt(input logic [1:0] k, input logic [15:0] a,
                                 input logic xr);
    case (k)
      2'd0: return (a[7:0] < 8'h80) ? 1 : ((a[7:0] == 8'h8E) ? 4 : 3);
      2'd1: return (a[7:0] < 8'h80) ? 1 : 2;
      2'd2: return xr ? 6 : 5;
      default: return (a >= 16'h0100 || xr) ? 6 : 5;
    endcase
  endfunction

  function automatic string tag_of(input int t, input logic [1:0] k,
                                   input logic [15:0] a);
    case (t)
      1: return "R1";
      2: return "R3";
      3: return "R2";
      4: return "R7";
      5: return "R4";
      default: return (k == 2'd3 && a >= 16'h0100) ? "R5" : "R6";
    endcase
  endfunction

  task automatic access(input logic [1:0] k, input logic [15:0] a,
                        input bit wr, input logic [7:0] d);
    int t;
    string tg;
    logic [7:0] exp_rd;
    @(negedge clk);
    req_kind = k; req_addr = a; req_wdata = d;
    req_rd = !wr; req_wr = wr;
    t  = exp_tgt(k, a, m_aux[1]);
    tg = tag_of(t, k, a);
    #1;
    chk(sfr_rd == (!wr && t == 3), "R2 sfr_rd", {15'd0, sfr_rd}, {15'd0, (!wr && t == 3)});
    chk(sfr_wr == (wr && t == 3), "R2 sfr_wr", {15'd0, sfr_wr}, {15'd0, (wr && t == 3)});
    if (t == 3) begin
      chk(sfr_addr == a[7:0], "R2 sfr_addr", {8'd0, sfr_addr}, {8'd0, a[7:0]});
      if (wr) chk(sfr_wdata == d, "R2 sfr_wdata", {8'd0, sfr_wdata}, {8'd0, d});
    end
    case (t)
      1: exp_rd = m_low[a[6:0]];
      2: exp_rd = m_high[a[6:0]];
      3: exp_rd = a[7:0] ^ 8'h5A;
      4: exp_rd = {5'd0, m_aux};
      5: exp_rd = m_eram[a[7:0]];
      default: exp_rd = 8'h00;
    endcase
    if (wr) begin
      case (t)
        1: m_low[a[6:0]]  = d;
        2: m_high[a[6:0]] = d;
        4: m_aux          = d[2:0];
        5: m_eram[a[7:0]] = d;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    req_rd = 1'b0; req_wr = 1'b0;
    chk(rd_valid == (!wr && t != 6), {"R9 rd_valid ", tg},
        {15'd0, rd_valid}, {15'd0, (!wr && t != 6)});
    if (!wr && t != 6)
      chk(rd_data == exp_rd, {tg, " rd_data"}, {8'd0, rd_data}, {8'd0, exp_rd});
    chk(ext_req == (t == 6), {"R10 ext_req ", tg}, {15'd0, ext_req}, {15'd0, (t == 6)});
    if (t == 6) begin
      chk(ext_addr == ((k == 2'd2) ? {8'h00, a[7:0]} : a), "R10 ext_addr",
          ext_addr, (k == 2'd2) ? {8'h00, a[7:0]} : a);
      chk(ext_ptr8 == (k == 2'd2), "R10 ext_ptr8", {15'd0, ext_ptr8}, {15'd0, (k == 2'd2)});
      chk(ext_we == wr, "R10 ext_we", {15'd0, ext_we}, {15'd0, wr});
      if (wr) chk(ext_wdata == d, "R10 ext_wdata", {8'd0, ext_wdata}, {8'd0, d});
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    @(posedge clk);
    #1;
    chk(!ext_req, "R10 pulse ends", {15'd0, ext_req}, 16'd0);
    chk(!rd_valid, "R9 no request", {15'd0, rd_valid}, 16'd0);
  endtask

  task automatic cfg_check();
    chk({cfg_lvadc, cfg_extram, cfg_ale_ctl} == m_aux, "R7 cfg pins",
        {13'd0, cfg_lvadc, cfg_extram, cfg_ale_ctl}, {13'd0, m_aux});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog expired act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_aux = 3'b110;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // reset state
    chk(cfg_extram == 1'b1, "R7 reset extram", {15'd0, cfg_extram}, 16'd1);
    chk(cfg_lvadc == 1'b1, "R7 reset lvadc", {15'd0, cfg_lvadc}, 16'd1);
    chk(cfg_ale_ctl == 1'b0, "R7 reset ale", {15'd0, cfg_ale_ctl}, 16'd0);
    chk(!rd_valid && !ext_req, "R9 reset outputs", {14'd0, rd_valid, ext_req}, 16'd0);

    access(2'd0, 16'h008E, 1'b0, 8'h00);        // R7 reads 06h
    access(2'd0, 16'h008E, 1'b1, 8'hFF);        // R8 reserved bits dropped
    cfg_check();
    access(2'd0, 16'h008E, 1'b0, 8'h00);        // R8 reads 07h
    access(2'd0, 16'h008E, 1'b1, 8'hF8);        // R8 only high bits set -> 000
    cfg_check();
    access(2'd0, 16'h008E, 1'b0, 8'h00);

    // fill every on-chip location (R1 R3 R4)
    for (int i = 0; i < 128; i++) begin
      access(2'd0, 16'(i), 1'b1, 8'($urandom));
      access(2'd1, 16'(i + 128), 1'b1, 8'($urandom));
    end
    for (int i = 0; i < 256; i++) access(2'd2, 16'(i), 1'b1, 8'($urandom));

    // three stores at A0h (R2 R3 R4)
    access(2'd1, 16'h00A0, 1'b1, 8'h11);
    access(2'd2, 16'h00A0, 1'b1, 8'h22);
    access(2'd0, 16'h00A0, 1'b0, 8'h00);
    access(2'd1, 16'h00A0, 1'b0, 8'h00);
    access(2'd3, 16'h00A0, 1'b0, 8'h00);
    access(2'd0, 16'h00A0, 1'b1, 8'h3C);        // R2 window write
    // R1 upper bits ignored, shared low store
    access(2'd0, 16'h3405, 1'b1, 8'h77);
    access(2'd1, 16'hC705, 1'b0, 8'h00);
    // R9 write then immediate read
    access(2'd2, 16'h0010, 1'b1, 8'hE1);
    access(2'd3, 16'h0010, 1'b0, 8'h00);
    // R5 high pointer off chip while bit clear
    access(2'd3, 16'h01A0, 1'b1, 8'h5E);
    idle_check();
    access(2'd3, 16'hFFFF, 1'b0, 8'h00);
    access(2'd3, 16'h00FF, 1'b0, 8'h00);
    // R6 bit set: everything off chip, ext RAM untouched
    access(2'd0, 16'h008E, 1'b1, 8'h02);
    cfg_check();
    access(2'd2, 16'h00A0, 1'b1, 8'h99);
    access(2'd3, 16'h00A0, 1'b1, 8'h98);
    access(2'd2, 16'h00A0, 1'b0, 8'h00);
    idle_check();
    access(2'd0, 16'h008E, 1'b1, 8'h00);
    access(2'd3, 16'h00A0, 1'b0, 8'h00);        // R6 still 22h
    access(2'd2, 16'h00A0, 1'b0, 8'h00);

    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      logic [1:0]  k;
      logic [15:0] a;
      bit          w;
      k = 2'($urandom);
      a = 16'($urandom);
      if (k == 2'd3 && ($urandom % 4) != 0) a[15:8] = 8'h00;
      w = ($urandom % 2) == 1;
      if (n % 60 == 0) begin
        k = 2'd0; a = 16'h008E; w = 1'b1;
      end
      access(k, a, w, 8'($urandom));
      if (n % 97 == 0) idle_check();
      if (n % 200 == 0) cfg_check();
    end
    cfg_check();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule